// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital core of a 12-bit successive-approximation converter. A start request, sampled on a rising clock edge while the block is idle, opens a conversion. The block then resolves one bit per clock, most significant bit first. For each bit it drives a trial code to an external DAC and reads back a single-bit comparator decision. When the last bit has been decided, it latches the result in two's-complement form and raises a done strobe for one cycle.

The internal trial code is offset binary. The comparator answers 1 when the sampled input is at or above the DAC level for the current trial. A hold output keeps the track/hold in hold for the whole conversion, and a busy flag marks the same interval. A conversion takes 13 clock cycles and cannot be restarted once it has begun. The analog comparator, the DAC and any host or bus interface sit outside this block.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy_o, hold_o and done_o are 0 and trial_o and result_o are zero. This also holds when reset arrives in the middle of a conversion.
- R2: A start_i sampled high on a rising edge while idle begins a conversion. In the cycle after that edge, busy_o and hold_o are 1 and trial_o equals 0x800, which is bit 11 set and all other bits clear.
- R3: busy_o stays high for exactly 13 cycles. done_o is 1 in the first cycle in which busy_o is low again.
- R4: Bits are resolved from bit 11 down to bit 0. After the first decision, trial_o bit 11 holds that decision, bit 10 is 1 and bits 9 to 0 are 0.
- R5: A tested bit is kept at 1 only if cmp_i is 1 on the edge where that bit is decided. Otherwise the bit is cleared. When the conversion ends, trial_o equals the sequence of decisions, MSB first.
- R6: result_o is the final trial code with bit 11 inverted, which gives two's complement. With an ideal comparator (cmp_i = 1 when V >= (trial − 2048)·10 V/4096), result_o equals floor(V·4096/10 V) for V in the ±5 V range.
- R7: A start_i that arrives while busy_o is 1, including the last busy cycle, is ignored. The conversion length stays the same, and no new conversion follows once start_i is low.
- R8: done_o is a single-cycle pulse. result_o keeps its value until the next done_o.
- R9: hold_o is 1 exactly when busy_o is 1. It returns to 0, the track state, on the same edge on which the conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change and every comparator decision happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Conversion request, sampled on the rising edge while idle |
| cmp_i | input | 1 | Comparator decision: 1 when the input is at or above the trial level |
| trial_o | output | 12 | Offset-binary trial code for the external DAC |
| hold_o | output | 1 | Track/hold control: 1 means hold |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when a new result is latched |
| result_o | output | 12 | Last conversion result in two's complement |

## Verification
The assertions assume that start_i and cmp_i are stable around each rising edge, so every decision is made on a settled value. They also assume reset is applied before the first conversion. The bench drives start_i and the comparator model on the falling edge and samples outputs there. The comparator is a pure function of the current trial code, so its answer has settled long before the next rising edge. Inputs are kept strictly inside the ±5 V span, so an ideal conversion never clips at full scale.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_FIN  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int W = 12,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          load_o,
  output logic          step_o,
  output logic          fin_o,
  output logic [IW-1:0] idx_o
);
  import sar_pkg::*;

  sar_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_CONV;
          idx_d   = IW'(W - 1);
        end
      end
      ST_CONV: begin
        step_o = 1'b1;
        if (idx_q == '0) state_d = ST_FIN;
        else             idx_d   = idx_q - 1'b1;
      end
      ST_FIN: begin
        fin_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign idx_o  = idx_q;
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int W = 12,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [IW-1:0] idx_i,
  input  logic          cmp_i,
  output logic [W-1:0]  trial_o
);
  logic [W-1:0] trial_q, trial_d;
  logic         en;

  assign en = load_i | step_i;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      trial_d[b] = trial_q[b];
      if (load_i)                                trial_d[b] = (b == W - 1);
      else if (step_i && int'(idx_i) == b)       trial_d[b] = cmp_i;
      else if (step_i && int'(idx_i) == b + 1)   trial_d[b] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  trial_q <= '0;
    else if (en) trial_q <= trial_d;
  end

  assign trial_o = trial_q;
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fin_i,
  input  logic [W-1:0] code_i,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  logic [W-1:0] res_q, res_d;
  logic         done_q;

  assign res_d = {~code_i[W-1], code_i[W-2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     res_q <= '0;
    else if (fin_i) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= fin_i;
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int W = 12,
  localparam int IW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [W-1:0] trial_o,
  output logic         hold_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  logic          busy, load, step, fin;
  logic [IW-1:0] idx;

  sar_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .busy_o(busy), .load_o(load), .step_o(step), .fin_o(fin), .idx_o(idx)
  );

  sar_trial #(.W(W)) u_trial (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
    .idx_i(idx), .cmp_i(cmp_i), .trial_o(trial_o)
  );

  sar_result #(.W(W)) u_result (
    .clk(clk), .rst_n(rst_n), .fin_i(fin), .code_i(trial_o),
    .result_o(result_o), .done_o(done_o)
  );

  assign busy_o = busy;
  assign hold_o = busy;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W = 12,
  localparam int CW = $clog2(W + 2) + 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] trial_o,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  assert_busy_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_cnt == CW'(W + 1));

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(result_o)));

  assert_first_trial_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> trial_o == {1'b1, {(W-1){1'b0}}});
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trial_o(trial_o), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o)
);

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         cmp;
  logic [W-1:0] trial, result;
  logic         hold, busy, done;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  longint       vin_uv = 0;
  bit           pat_mode = 0;
  logic [W-1:0] pat = '0;

  always #10 clk = ~clk;

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmp_i(cmp),
    .trial_o(trial), .hold_o(hold), .busy_o(busy), .done_o(done),
    .result_o(result)
  );

  function automatic int low_bit(logic [W-1:0] v);
    for (int i = 0; i < W; i++) if (v[i]) return i;
    return 0;
  endfunction

  // comparator model: ideal threshold, 1 LSB = 10 V / 4096
  always_comb begin
    if (pat_mode) cmp = pat[low_bit(trial)];
    else          cmp = (vin_uv * 4096) >= ((longint'(trial) - 2048) * 10_000_000);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_code(longint uv);
    longint e = uv * 4096;
    if (e >= 0) return e / 10_000_000;
    return -(((-e) + 10_000_000 - 1) / 10_000_000);
  endfunction

  // runs one conversion; extra=1 pulses start while busy, including last cycle
  task automatic run_conv(bit extra, output logic [W-1:0] res, output logic [W-1:0] fin_trial);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(hold == 1'b1, "R9", "hold after start", hold, 1);
    chk(trial == 12'h800, "R2", "first trial", trial, 12'h800);
    n = 1;
    for (int k = 0; k < 40; k++) begin
      start = extra && (n == 5 || n == 6 || n == 13);
      @(negedge clk);
      if (!busy) break;
      n++;
      if (done) chk(1'b0, "R3", "done while busy", 1, 0);
    end
    start = 1'b0;
    chk(n == 13, "R3", "busy cycles", n, 13);
    chk(done == 1'b1, "R3", "done at end", done, 1);
    chk(hold == 1'b0, "R9", "hold back to track", hold, 0);
    res = result;
    fin_trial = trial;
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", done, 0);
    chk(result == res, "R8", "result held", result, res);
    if (extra) chk(busy == 1'b0, "R7", "no restart from ignored start", busy, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && hold == 0 && done == 0, "R1", "flags in reset", {busy, hold, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trial == 0, "R1", "trial after reset", trial, 0);
    chk(result == 0, "R1", "result after reset", result, 0);
    chk(busy == 0 && done == 0, "R1", "idle after reset", {busy, done}, 0);
  endtask

  task automatic t_ideal(longint uv, bit extra);
    logic [W-1:0] r, t;
    longint e;
    pat_mode = 0; vin_uv = uv;
    run_conv(extra, r, t);
    e = exp_code(uv);
    chk(r == W'(e), "R6", $sformatf("code for %0d uV", uv), $signed(r), e);
    chk(r == {~t[W-1], t[W-2:0]}, "R6", "msb inverted", r, {~t[W-1], t[W-2:0]});
  endtask

  task automatic t_pattern(logic [W-1:0] p);
    logic [W-1:0] r, t;
    pat_mode = 1; pat = p;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(trial == ({p[11], 11'b0} | 12'h400), "R4", "trial after first decision",
        trial, {p[11], 11'b0} | 12'h400);
    for (int k = 0; k < 40; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    t = trial; r = result;
    chk(t == p, "R5", "final trial equals decisions", t, p);
    chk(r == (p ^ 12'h800), "R6", "pattern result", r, p ^ 12'h800);
    pat_mode = 0;
    @(negedge clk);
  endtask

  task automatic t_mid_reset();
    pat_mode = 0; vin_uv = 1_000_000;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #3;
    chk(busy == 0 && hold == 0, "R1", "reset aborts conversion", {busy, hold}, 0);
    chk(result == 0 && trial == 0, "R1", "reset clears codes", result, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (16) @(negedge clk);
    chk(done == 0 && busy == 0, "R1", "stays idle after abort", {busy, done}, 0);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    t_reset();
    t_ideal(0, 0);
    t_ideal(2442, 0);
    t_ideal(-1, 0);
    t_ideal(4_999_999, 0);
    t_ideal(-5_000_000, 1);
    t_ideal(1_234_567, 1);
    t_ideal(-3_333_333, 0);
    t_pattern(12'hA5C);
    t_pattern(12'h001);
    t_pattern(12'hFFE);
    t_mid_reset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule